// File: doc/BRIEF.md
# Per-Destination Page Queue Manager

This block keeps the address bookkeeping for a shared packet buffer that is split into equal pages, each as long as one transmission slot. Every destination, selected by an 11-bit tag, owns a first-in first-out chain of pages. A writer asks to append a burst of a known byte length to a destination. The block answers in the same cycle with the page and offset where the burst lands. When the burst does not fit in the last page, it also names a freshly allocated page that takes the remainder. A reader asks to drain up to a given number of bytes from the first page of a destination. The block answers in the same cycle with the page, offset and exact byte count, and it frees the page once its last byte has been read.

Per destination, the table keeps the first page, the last page, the write offset inside the last page, the read offset inside the first page and the number of useful bytes queued. A per-page link memory chains the pages together. A free-page FIFO supplies new pages and takes back drained ones. A write and a read may name the same destination in the same cycle. The read is then applied to the state as it stood before the cycle, the write is applied on top of that result, and both are folded into one entry update.

Top module: `plm_page_lists`

## Requirements
- R1: After reset every destination reports empty with zero queued bytes, and the free pool holds every page in the order 0, 1, 2, and so on upward.
- R2: A write to a destination with no page takes the next page from the pool and reports that page at offset 0 with a spill of 0.
- R3: A write whose length fits in the room left in the last page reports that page and the current write offset. The write offset then advances by the length.
- R4: A write longer than the room left reports the old last page and offset. The part that overflows is reported as `wr_spill_o`, placed at offset 0 of a newly allocated page, and that page is linked behind the old last page.
- R5: A write of length 0, a write longer than a page, and a write that needs a page while the pool is empty each give `wr_ok_o`=0, and none of them changes the destination.
- R6: A read of a destination with no useful bytes gives `rd_empty_o`=1, `rd_len_o`=0 and `rd_avail_o`=0, and changes no state.
- R7: A read moves min(`rd_max_i`, bytes left in the first page) bytes, starting at the read offset of the first page. Before the read, `rd_avail_o` reports the total useful bytes queued.
- R8: While the first and last pages are the same page, a read never passes the write offset.
- R9: A read that reaches the end of a full page returns that page to the pool. The next page in the chain becomes the first page, at offset 0. If no page follows, the destination becomes empty.
- R10: When a write and a read name the same destination in one cycle, the read sees the state from before the cycle, the write is applied after it, and neither update is lost.
- R11: Pages leave and re-enter the pool in FIFO order, so a freed page is reused only after every page that was already in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Append request |
| wr_dest_i | input | TAG_W | Destination tag for the append |
| wr_len_i | input | OFF_W | Burst length in bytes |
| wr_ok_o | output | 1 | Append accepted |
| wr_page_o | output | PAGE_W | Page where the burst starts |
| wr_off_o | output | OFF_W | Byte offset where the burst starts |
| wr_spill_o | output | OFF_W | Bytes that go into the new page (0 if none) |
| wr_spill_page_o | output | PAGE_W | Page that takes the spilled bytes |
| rd_req_i | input | 1 | Drain request |
| rd_dest_i | input | TAG_W | Destination tag for the drain |
| rd_max_i | input | OFF_W | Largest number of bytes to drain |
| rd_empty_o | output | 1 | Destination has no useful bytes |
| rd_page_o | output | PAGE_W | First page being drained |
| rd_off_o | output | OFF_W | Read offset inside the first page |
| rd_len_o | output | OFF_W | Bytes drained by this request |
| rd_avail_o | output | CNT_W | Useful bytes queued before this request |

## Verification
On every cycle, the assertions bound each drain by its limit and by the queued total. They keep a drain on a shared first and last page below the write offset, and they force an empty drain to move nothing. They also make every spill add up to a page boundary in a different page, reject malformed lengths, and keep the free pool from overflowing or underflowing. The page numbers handed out and the order in which freed pages return can only be shown by the bench's scenarios. The same holds for how a chain advances after a page is drained, and for the merged outcome when both requests name one destination. Those scenarios walk a scripted sequence of appends and drains, then drain the pool completely.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int DEF_TAG_W      = 11;
  localparam int DEF_NUM_PAGES  = 64;
  localparam int DEF_PAGE_BYTES = 1024;
endpackage

// File: rtl/plm_free_fifo.sv
module plm_free_fifo #(
  parameter int NUM_PAGES = 64,
  parameter int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_page_i,
  output logic [PAGE_W-1:0] head_o,
  output logic              nonempty_o
);
  localparam int CW = $clog2(NUM_PAGES + 1);

  logic [PAGE_W-1:0] slot_q [NUM_PAGES];
  logic [PAGE_W-1:0] rd_q, wr_q;
  logic [CW-1:0]     cnt_q;

  assign head_o     = slot_q[rd_q];
  assign nonempty_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PAGES; i++) slot_q[i] <= PAGE_W'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(NUM_PAGES);
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= push_page_i;
        wr_q <= (wr_q == PAGE_W'(NUM_PAGES - 1)) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) rd_q <= (rd_q == PAGE_W'(NUM_PAGES - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CW'(NUM_PAGES)));
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/plm_rd_step.sv
module plm_rd_step #(
  parameter int PAGE_W     = 6,
  parameter int OFF_W      = 11,
  parameter int CNT_W      = 17,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              en_i,
  input  logic [OFF_W-1:0]  max_i,
  input  logic              e_valid_i,
  input  logic [PAGE_W-1:0] e_head_i,
  input  logic [PAGE_W-1:0] e_tail_i,
  input  logic [OFF_W-1:0]  e_wro_i,
  input  logic [OFF_W-1:0]  e_rdo_i,
  input  logic [CNT_W-1:0]  e_cnt_i,
  input  logic [PAGE_W-1:0] next_head_i,
  output logic              n_valid_o,
  output logic [PAGE_W-1:0] n_head_o,
  output logic [PAGE_W-1:0] n_tail_o,
  output logic [OFF_W-1:0]  n_wro_o,
  output logic [OFF_W-1:0]  n_rdo_o,
  output logic [CNT_W-1:0]  n_cnt_o,
  output logic              empty_o,
  output logic [OFF_W-1:0]  take_o,
  output logic              free_o
);
  logic [OFF_W-1:0] end_lim, avail;
  logic             reach;

  always_comb begin
    end_lim = (e_head_i == e_tail_i) ? e_wro_i : OFF_W'(PAGE_BYTES);
    avail   = end_lim - e_rdo_i;
    empty_o = !e_valid_i || (e_cnt_i == '0);
    take_o  = empty_o ? '0 : ((max_i < avail) ? max_i : avail);
    reach   = !empty_o &&
              (({1'b0, e_rdo_i} + {1'b0, take_o}) == (OFF_W + 1)'(PAGE_BYTES));
    free_o  = en_i && reach;

    n_valid_o = e_valid_i;
    n_head_o  = e_head_i;
    n_tail_o  = e_tail_i;
    n_wro_o   = e_wro_i;
    n_rdo_o   = e_rdo_i;
    n_cnt_o   = e_cnt_i;
    if (en_i && !empty_o) begin
      n_cnt_o = e_cnt_i - CNT_W'(take_o);
      if (reach) begin
        if (e_head_i == e_tail_i) n_valid_o = 1'b0;
        else begin
          n_head_o = next_head_i;
          n_rdo_o  = '0;
        end
      end else begin
        n_rdo_o = e_rdo_i + take_o;
      end
    end
  end
endmodule

// File: rtl/plm_wr_step.sv
module plm_wr_step #(
  parameter int PAGE_W     = 6,
  parameter int OFF_W      = 11,
  parameter int CNT_W      = 17,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              en_i,
  input  logic [OFF_W-1:0]  len_i,
  input  logic              pool_ok_i,
  input  logic [PAGE_W-1:0] pool_page_i,
  input  logic              e_valid_i,
  input  logic [PAGE_W-1:0] e_head_i,
  input  logic [PAGE_W-1:0] e_tail_i,
  input  logic [OFF_W-1:0]  e_wro_i,
  input  logic [OFF_W-1:0]  e_rdo_i,
  input  logic [CNT_W-1:0]  e_cnt_i,
  output logic              n_valid_o,
  output logic [PAGE_W-1:0] n_head_o,
  output logic [PAGE_W-1:0] n_tail_o,
  output logic [OFF_W-1:0]  n_wro_o,
  output logic [OFF_W-1:0]  n_rdo_o,
  output logic [CNT_W-1:0]  n_cnt_o,
  output logic              ok_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [OFF_W-1:0]  spill_o,
  output logic              alloc_o,
  output logic              link_o
);
  logic [OFF_W-1:0] room;
  logic             len_ok, over, need, act;

  always_comb begin
    room    = OFF_W'(PAGE_BYTES) - e_wro_i;
    len_ok  = (len_i != '0) && (len_i <= OFF_W'(PAGE_BYTES));
    over    = e_valid_i && (len_i > room);
    need    = !e_valid_i || over;
    ok_o    = len_ok && (!need || pool_ok_i);
    act     = en_i && ok_o;
    page_o  = e_valid_i ? e_tail_i : pool_page_i;
    off_o   = e_valid_i ? e_wro_i : '0;
    spill_o = over ? (len_i - room) : '0;
    alloc_o = act && need;
    link_o  = act && over;

    n_valid_o = e_valid_i;
    n_head_o  = e_head_i;
    n_tail_o  = e_tail_i;
    n_wro_o   = e_wro_i;
    n_rdo_o   = e_rdo_i;
    n_cnt_o   = e_cnt_i;
    if (act) begin
      if (!e_valid_i) begin
        n_valid_o = 1'b1;
        n_head_o  = pool_page_i;
        n_tail_o  = pool_page_i;
        n_rdo_o   = '0;
        n_wro_o   = len_i;
        n_cnt_o   = CNT_W'(len_i);
      end else if (over) begin
        n_tail_o = pool_page_i;
        n_wro_o  = len_i - room;
        n_cnt_o  = e_cnt_i + CNT_W'(len_i);
      end else begin
        n_wro_o = e_wro_i + len_i;
        n_cnt_o = e_cnt_i + CNT_W'(len_i);
      end
    end
  end
endmodule

// File: rtl/plm_page_lists.sv
module plm_page_lists
  import plm_pkg::*;
#(
  parameter int  TAG_W      = DEF_TAG_W,
  parameter int  NUM_PAGES  = DEF_NUM_PAGES,
  parameter int  PAGE_BYTES = DEF_PAGE_BYTES,
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int OFF_W      = $clog2(PAGE_BYTES + 1),
  localparam int CNT_W      = $clog2(NUM_PAGES * PAGE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [TAG_W-1:0]  wr_dest_i,
  input  logic [OFF_W-1:0]  wr_len_i,
  output logic              wr_ok_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [OFF_W-1:0]  wr_spill_o,
  output logic [PAGE_W-1:0] wr_spill_page_o,
  input  logic              rd_req_i,
  input  logic [TAG_W-1:0]  rd_dest_i,
  input  logic [OFF_W-1:0]  rd_max_i,
  output logic              rd_empty_o,
  output logic [PAGE_W-1:0] rd_page_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic [OFF_W-1:0]  rd_len_o,
  output logic [CNT_W-1:0]  rd_avail_o
);
  localparam int NUM_DEST = 1 << TAG_W;

  logic [NUM_DEST-1:0] valid_q;
  logic [PAGE_W-1:0]   head_q [NUM_DEST];
  logic [PAGE_W-1:0]   tail_q [NUM_DEST];
  logic [OFF_W-1:0]    wro_q  [NUM_DEST];
  logic [OFF_W-1:0]    rdo_q  [NUM_DEST];
  logic [CNT_W-1:0]    cnt_q  [NUM_DEST];
  logic [PAGE_W-1:0]   next_q [NUM_PAGES];

  // read side view of the entry
  logic              r_valid;
  logic [PAGE_W-1:0] r_head, r_tail;
  logic [OFF_W-1:0]  r_wro, r_rdo;
  logic [CNT_W-1:0]  r_cnt;
  assign r_valid = valid_q[rd_dest_i];
  assign r_head  = head_q[rd_dest_i];
  assign r_tail  = tail_q[rd_dest_i];
  assign r_wro   = wro_q[rd_dest_i];
  assign r_rdo   = rdo_q[rd_dest_i];
  assign r_cnt   = cnt_q[rd_dest_i];

  logic              rn_valid;
  logic [PAGE_W-1:0] rn_head, rn_tail;
  logic [OFF_W-1:0]  rn_wro, rn_rdo;
  logic [CNT_W-1:0]  rn_cnt;
  logic              rd_free;

  plm_rd_step #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_rd (
    .en_i(rd_req_i), .max_i(rd_max_i),
    .e_valid_i(r_valid), .e_head_i(r_head), .e_tail_i(r_tail),
    .e_wro_i(r_wro), .e_rdo_i(r_rdo), .e_cnt_i(r_cnt),
    .next_head_i(next_q[r_head]),
    .n_valid_o(rn_valid), .n_head_o(rn_head), .n_tail_o(rn_tail),
    .n_wro_o(rn_wro), .n_rdo_o(rn_rdo), .n_cnt_o(rn_cnt),
    .empty_o(rd_empty_o), .take_o(rd_len_o), .free_o(rd_free)
  );

  assign rd_page_o  = r_head;
  assign rd_off_o   = r_rdo;
  assign rd_avail_o = r_valid ? r_cnt : '0;

  // write acts on the post-read entry when both name one destination
  logic              same_dest;
  logic              w_valid;
  logic [PAGE_W-1:0] w_head, w_tail;
  logic [OFF_W-1:0]  w_wro, w_rdo;
  logic [CNT_W-1:0]  w_cnt;
  assign same_dest = rd_req_i && (rd_dest_i == wr_dest_i);

  always_comb begin
    if (same_dest) begin
      w_valid = rn_valid; w_head = rn_head; w_tail = rn_tail;
      w_wro   = rn_wro;   w_rdo  = rn_rdo;  w_cnt  = rn_cnt;
    end else begin
      w_valid = valid_q[wr_dest_i]; w_head = head_q[wr_dest_i];
      w_tail  = tail_q[wr_dest_i];  w_wro  = wro_q[wr_dest_i];
      w_rdo   = rdo_q[wr_dest_i];   w_cnt  = cnt_q[wr_dest_i];
    end
  end

  logic              wn_valid;
  logic [PAGE_W-1:0] wn_head, wn_tail;
  logic [OFF_W-1:0]  wn_wro, wn_rdo;
  logic [CNT_W-1:0]  wn_cnt;
  logic              pool_ok, alloc, link;
  logic [PAGE_W-1:0] pool_page;

  plm_wr_step #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_wr (
    .en_i(wr_req_i), .len_i(wr_len_i),
    .pool_ok_i(pool_ok), .pool_page_i(pool_page),
    .e_valid_i(w_valid), .e_head_i(w_head), .e_tail_i(w_tail),
    .e_wro_i(w_wro), .e_rdo_i(w_rdo), .e_cnt_i(w_cnt),
    .n_valid_o(wn_valid), .n_head_o(wn_head), .n_tail_o(wn_tail),
    .n_wro_o(wn_wro), .n_rdo_o(wn_rdo), .n_cnt_o(wn_cnt),
    .ok_o(wr_ok_o), .page_o(wr_page_o), .off_o(wr_off_o), .spill_o(wr_spill_o),
    .alloc_o(alloc), .link_o(link)
  );

  assign wr_spill_page_o = pool_page;

  plm_free_fifo #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_pool (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pop_i(alloc), .push_i(rd_free), .push_page_i(r_head),
    .head_o(pool_page), .nonempty_o(pool_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else begin
      if (rd_req_i) valid_q[rd_dest_i] <= rn_valid;
      if (wr_req_i) valid_q[wr_dest_i] <= wn_valid;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_req_i) begin
      head_q[rd_dest_i] <= rn_head; tail_q[rd_dest_i] <= rn_tail;
      wro_q[rd_dest_i]  <= rn_wro;  rdo_q[rd_dest_i]  <= rn_rdo;
      cnt_q[rd_dest_i]  <= rn_cnt;
    end
    if (wr_req_i) begin
      head_q[wr_dest_i] <= wn_head; tail_q[wr_dest_i] <= wn_tail;
      wro_q[wr_dest_i]  <= wn_wro;  rdo_q[wr_dest_i]  <= wn_rdo;
      cnt_q[wr_dest_i]  <= wn_cnt;
    end
    if (link) next_q[w_tail] <= pool_page;
  end

  // R5
  wr_len_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && ((wr_len_i == '0) || (wr_len_i > OFF_W'(PAGE_BYTES)))) |-> !wr_ok_o);
  // R4
  spill_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && wr_ok_o && (wr_spill_o != '0)) |->
    ((wr_spill_page_o != wr_page_o) &&
     (({1'b0, wr_off_o} + {1'b0, wr_len_i}) == ((OFF_W + 1)'(PAGE_BYTES) + {1'b0, wr_spill_o}))));
  // R6
  rd_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_empty_o) |-> (rd_len_o == '0));
  // R7
  rd_len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |-> ((rd_len_o <= rd_max_i) && (CNT_W'(rd_len_o) <= rd_avail_o)));
  // R8
  rd_same_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_empty_o && (r_head == r_tail)) |->
    (({1'b0, rd_off_o} + {1'b0, rd_len_o}) <= {1'b0, r_wro}));
endmodule

// File: tb/plm_page_lists_bench.sv
module plm_page_lists_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [10:0] wr_dest_i = '0;
  logic [10:0] wr_len_i = '0;
  logic        wr_ok_o;
  logic [5:0]  wr_page_o;
  logic [10:0] wr_off_o;
  logic [10:0] wr_spill_o;
  logic [5:0]  wr_spill_page_o;
  logic        rd_req_i = 1'b0;
  logic [10:0] rd_dest_i = '0;
  logic [10:0] rd_max_i = '0;
  logic        rd_empty_o;
  logic [5:0]  rd_page_o;
  logic [10:0] rd_off_o;
  logic [10:0] rd_len_o;
  logic [16:0] rd_avail_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  plm_page_lists u_plm_page_lists (
    .clk_i, .rst_ni,
    .wr_req_i, .wr_dest_i, .wr_len_i, .wr_ok_o, .wr_page_o, .wr_off_o,
    .wr_spill_o, .wr_spill_page_o,
    .rd_req_i, .rd_dest_i, .rd_max_i, .rd_empty_o, .rd_page_o, .rd_off_o,
    .rd_len_o, .rd_avail_o
  );

  typedef struct packed {
    bit        we; bit [10:0] wd; bit [10:0] wl;
    bit        re; bit [10:0] rd; bit [10:0] rm;
    bit        ok; bit [5:0] wp; bit [10:0] wo; bit [10:0] ws; bit [5:0] sp;
    bit        emp; bit [5:0] rp; bit [10:0] ro; bit [10:0] rl; bit [16:0] ra;
    bit [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1, 5, 100,  0, 0, 0,       1, 0, 0, 0, 0,        0, 0, 0, 0, 0,          2},  // R2 first page
    '{1, 5, 900,  0, 0, 0,       1, 0, 100, 0, 0,      0, 0, 0, 0, 0,          3},  // R3 fits
    '{1, 5, 200,  0, 0, 0,       1, 0, 1000, 176, 1,   0, 0, 0, 0, 0,          4},  // R4 spill
    '{0, 0, 0,    1, 7, 50,      0, 0, 0, 0, 0,        1, 0, 0, 0, 0,          6},  // R6 never written
    '{0, 0, 0,    1, 5, 300,     0, 0, 0, 0, 0,        0, 0, 0, 300, 1200,     7},  // R7 partial
    '{0, 0, 0,    1, 5, 1024,    0, 0, 0, 0, 0,        0, 0, 300, 724, 900,    9},  // R9 page end
    '{0, 0, 0,    1, 5, 1024,    0, 0, 0, 0, 0,        0, 1, 0, 176, 176,      8},  // R8 stop at wr off
    '{0, 0, 0,    1, 5, 10,      0, 0, 0, 0, 0,        1, 0, 0, 0, 0,          6},  // R6 drained
    '{1, 5, 48,   0, 0, 0,       1, 1, 176, 0, 0,      0, 0, 0, 0, 0,          3},  // R3 append
    '{1, 5, 900,  1, 5, 1024,    1, 1, 224, 100, 2,    0, 1, 176, 48, 48,      10}, // R10 both
    '{0, 0, 0,    1, 5, 1024,    0, 0, 0, 0, 0,        0, 1, 224, 800, 900,    9},  // R9 R10
    '{0, 0, 0,    1, 5, 1024,    0, 0, 0, 0, 0,        0, 2, 0, 100, 100,      10}, // R10
    '{1, 9, 0,    0, 0, 0,       0, 0, 0, 0, 0,        0, 0, 0, 0, 0,          5},  // R5 zero
    '{1, 9, 1025, 0, 0, 0,       0, 0, 0, 0, 0,        0, 0, 0, 0, 0,          5},  // R5 too long
    '{0, 0, 0,    1, 9, 5,       0, 0, 0, 0, 0,        1, 0, 0, 0, 0,          5},  // R5 no change
    '{1, 9, 1024, 0, 0, 0,       1, 3, 0, 0, 0,        0, 0, 0, 0, 0,          11}, // R11 order
    '{1, 9, 1,    1, 9, 1024,    1, 4, 0, 0, 0,        0, 3, 0, 1024, 1024,    10}, // R10 free+alloc
    '{0, 0, 0,    1, 9, 1024,    0, 0, 0, 0, 0,        0, 4, 0, 1, 1,          10}, // R10
    '{0, 0, 0,    1, 2047, 1,    0, 0, 0, 0, 0,        1, 0, 0, 0, 0,          6}   // R6 top tag
  };

  task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic drive(input bit we, input int wd, input int wl, input bit re, input int rd, input int rm);
    @(negedge clk_i);
    wr_req_i  = we; wr_dest_i = 11'(wd); wr_len_i = 11'(wl);
    rd_req_i  = re; rd_dest_i = 11'(rd); rd_max_i = 11'(rm);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_req_i = 1'b0; rd_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    drive(0, 0, 0, 1, 0, 16);
    chk(1, "rd_empty", rd_empty_o, 1);
    chk(1, "rd_avail", rd_avail_o, 0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].we, TBL[i].wd, TBL[i].wl, TBL[i].re, TBL[i].rd, TBL[i].rm);
      if (TBL[i].we) begin
        chk(TBL[i].req, "wr_ok", wr_ok_o, TBL[i].ok);
        if (TBL[i].ok) begin
          chk(TBL[i].req, "wr_page", wr_page_o, TBL[i].wp);
          chk(TBL[i].req, "wr_off", wr_off_o, TBL[i].wo);
          chk(TBL[i].req, "wr_spill", wr_spill_o, TBL[i].ws);
          if (TBL[i].ws != 0) chk(TBL[i].req, "wr_spill_page", wr_spill_page_o, TBL[i].sp);
        end
      end
      if (TBL[i].re) begin
        chk(TBL[i].req, "rd_empty", rd_empty_o, TBL[i].emp);
        chk(TBL[i].req, "rd_len", rd_len_o, TBL[i].rl);
        chk(TBL[i].req, "rd_avail", rd_avail_o, TBL[i].ra);
        if (!TBL[i].emp) begin
          chk(TBL[i].req, "rd_page", rd_page_o, TBL[i].rp);
          chk(TBL[i].req, "rd_off", rd_off_o, TBL[i].ro);
        end
      end
    end

    // R1 reset clears lists and refills the pool
    do_reset();
    drive(0, 0, 0, 1, 5, 1024);
    chk(1, "rd_empty after reset", rd_empty_o, 1);

    // R1 R11 pool hands out 0..63 in order
    for (int p = 0; p < 64; p++) begin
      drive(1, 100 + p, 1024, 0, 0, 0);
      chk(11, "wr_ok exhaust", wr_ok_o, 1);
      chk(11, "wr_page exhaust", wr_page_o, p);
    end
    // R5 pool empty
    drive(1, 300, 1, 0, 0, 0);
    chk(5, "wr_ok pool empty", wr_ok_o, 0);
    drive(1, 100, 5, 0, 0, 0);
    chk(5, "wr_ok full tail", wr_ok_o, 0);
    // R5 rejected write left dest 100 intact; R9 single full page freed
    drive(0, 0, 0, 1, 100, 1024);
    chk(5, "rd_avail after reject", rd_avail_o, 1024);
    chk(9, "rd_len full page", rd_len_o, 1024);
    drive(0, 0, 0, 1, 100, 1024);
    chk(9, "rd_empty after last page", rd_empty_o, 1);
    // R11 freed page reused
    drive(1, 300, 1, 0, 0, 0);
    chk(11, "wr_ok reuse", wr_ok_o, 1);
    chk(11, "wr_page reuse", wr_page_o, 0);

    @(negedge clk_i);
    wr_req_i = 1'b0; rd_req_i = 1'b0;
    finish_run();
  end
endmodule